// File: doc/BRIEF.md
# Signal Unit Error Rate Monitor

This block watches the stream of received signaling units on a signaling link and decides when the link's error rate has grown too high. It works as a leaky bucket. Every errored unit adds one to an error count. Every completed block of units lets one error drain away. If an errored unit arrives while the count already stands at the selected threshold, the block raises an interrupt status bit and starts monitoring again from zero.

A unit validator upstream feeds it single-cycle pulses. One pulse marks a good unit and another marks an errored one. A qualifier says that the errored unit came from an aborted or invalid frame. If the excess came from such a frame, the monitor keeps raising the interrupt on every later errored unit until a good unit arrives. A software-side register stage supplies the threshold select, the counter clear command, the interrupt mask and a write-one-to-clear pulse for the status bit. Both counters are exposed as read-only values.

Top module: `su_err_monitor`

## Requirements
- R1: After reset, the unit count, the error count, the interrupt status bit and the interrupt line are all zero.
- R2: Every cycle in which `unit_ok_i` or `unit_err_i` is high counts as one unit, and `su_cnt_o` rises by one on the next clock edge. A cycle with both pulses high counts as a single errored unit.
- R3: Every errored unit (`unit_err_i` high) adds one to `err_cnt_o` on the next clock edge.
- R4: The unit that moves `su_cnt_o` from 255 back to 0 completes a block. On that edge `err_cnt_o` drops by one, but never below zero. If that unit is itself errored, the two changes cancel and `err_cnt_o` keeps its value.
- R5: The threshold is 64 when `thr_sel_i` is 0 and 32 when `thr_sel_i` is 1. An errored unit that finds `err_cnt_o` at or above the threshold, and does not complete a block, is an excess. On that edge `err_cnt_o` returns to 0 and `irq_stat_o` is set.
- R6: `irq_o` is high exactly when `irq_stat_o` is high and `irq_mask_i` is low. The mask has no effect on `irq_stat_o`.
- R7: `irq_stat_o` stays set until a cycle with `stat_clr_i` high, which clears it on the next edge. If a new interrupt event occurs in that same cycle, the set wins.
- R8: A cycle with `cnt_clr_i` high clears both counters on the next edge. This takes priority over any unit pulse in that cycle.
- R9: If an excess unit has `unit_inval_i` high, then every later errored unit sets `irq_stat_o` again. This continues until a good-only unit (`unit_ok_i` high, `unit_err_i` low) arrives. After an excess without `unit_inval_i`, later errored units below the threshold do not set the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_ok_i | input | 1 | Pulse: a valid signaling unit was received |
| unit_err_i | input | 1 | Pulse: an errored signaling unit was received |
| unit_inval_i | input | 1 | Qualifier for `unit_err_i`: the unit came from an aborted or invalid frame |
| thr_sel_i | input | 1 | Threshold select: 0 gives 64, 1 gives 32 |
| cnt_clr_i | input | 1 | Command that clears both counters |
| irq_mask_i | input | 1 | 1 blocks the interrupt line |
| stat_clr_i | input | 1 | Write-one-to-clear pulse for the status bit |
| irq_stat_o | output | 1 | Sticky interrupt status |
| irq_o | output | 1 | Interrupt line, active high |
| su_cnt_o | output | 8 | Unit counter value within the current block |
| err_cnt_o | output | 7 | Errored unit (leaky bucket) counter value |

## Verification
Every result is one register away from its stimulus. A unit pulse, clear command or status-clear held across one rising edge shows up in the counters and the status bit right after that edge. The interrupt line follows the status bit and the mask with no further delay. The bench drives each input on a falling edge and holds it across exactly one rising edge. It samples on the next falling edge, so every check reads the value due one edge after its stimulus. Threshold and block checks read the counter one unit before and one unit after each boundary.

// File: rtl/su_mon_pkg.sv
package su_mon_pkg;

   // interrupt event reported by the error bucket to the status logic
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_EXCESS = 2'd1,
      EV_REPEAT = 2'd2
   } irq_ev_e;

   // minimal width able to hold the value n
   function automatic int unsigned width_of(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/su_block_ctr.sv
module su_block_ctr #(
   parameter int unsigned BLOCK = 256,
   parameter int unsigned CW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          unit_i,
   output logic [CW-1:0] cnt_o,
   output logic          wrap_o
);

   localparam logic [CW-1:0] LAST = CW'(BLOCK - 1);
   localparam bit            POW2 = ((BLOCK & (BLOCK - 1)) == 0);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign wrap_o  = unit_i && at_last && !clr_i;

   generate
      if (POW2) begin : g_pow2
         // width equals log2 of the block size, the adder wraps by itself
         assign cnt_inc = cnt_q + 1'b1;
      end else begin : g_mod
         assign cnt_inc = at_last ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (unit_i) begin
         cnt_q <= cnt_inc;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/su_err_bucket.sv
module su_err_bucket
   import su_mon_pkg::*;
#(
   parameter int unsigned THR_HI = 64,
   parameter int unsigned THR_LO = 32,
   parameter int unsigned EW     = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          err_i,
   input  logic          inval_i,
   input  logic          ok_i,
   input  logic          leak_i,
   input  logic          thr_sel_i,
   output logic [EW-1:0] cnt_o,
   output irq_ev_e       ev_o
);

   localparam logic [EW-1:0] T_HI = EW'(THR_HI);
   localparam logic [EW-1:0] T_LO = EW'(THR_LO);

   logic [EW-1:0] cnt_q;
   logic [EW-1:0] cnt_d;
   logic [EW-1:0] thr;
   logic          excess;
   logic          rpt_q;

   generate
      if (THR_HI == THR_LO) begin : g_fixed_thr
         assign thr = T_HI;
      end else begin : g_sel_thr
         assign thr = thr_sel_i ? T_LO : T_HI;
      end
   endgenerate

   assign excess = err_i && !leak_i && !clr_i && (cnt_q >= thr);

   always_comb begin
      cnt_d = cnt_q;
      if (clr_i || excess) begin
         cnt_d = '0;
      end else begin
         unique case ({err_i, leak_i})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            default: cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rpt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (excess && inval_i) begin
            rpt_q <= 1'b1;
         end else if (ok_i && !err_i) begin
            rpt_q <= 1'b0;
         end
      end
   end

   always_comb begin
      if (excess) begin
         ev_o = EV_EXCESS;
      end else if (rpt_q && err_i) begin
         ev_o = EV_REPEAT;
      end else begin
         ev_o = EV_NONE;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/su_irq_ctrl.sv
module su_irq_ctrl
   import su_mon_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  irq_ev_e ev_i,
   input  logic    stat_clr_i,
   input  logic    mask_i,
   output logic    stat_o,
   output logic    irq_o
);

   logic stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
      end else if (ev_i != EV_NONE) begin
         stat_q <= 1'b1;
      end else if (stat_clr_i) begin
         stat_q <= 1'b0;
      end
   end

   assign stat_o = stat_q;
   assign irq_o  = stat_q && !mask_i;

endmodule

// File: rtl/su_err_monitor.sv
module su_err_monitor
   import su_mon_pkg::*;
#(
   parameter int unsigned BLOCK  = 256,
   parameter int unsigned THR_HI = 64,
   parameter int unsigned THR_LO = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 unit_ok_i,
   input  logic                                 unit_err_i,
   input  logic                                 unit_inval_i,
   input  logic                                 thr_sel_i,
   input  logic                                 cnt_clr_i,
   input  logic                                 irq_mask_i,
   input  logic                                 stat_clr_i,
   output logic                                 irq_stat_o,
   output logic                                 irq_o,
   output logic [su_mon_pkg::width_of(BLOCK-1)-1:0] su_cnt_o,
   output logic [su_mon_pkg::width_of(THR_HI)-1:0]  err_cnt_o
);

   localparam int unsigned SU_W  = width_of(BLOCK - 1);
   localparam int unsigned ERR_W = width_of(THR_HI);

   generate
      if (BLOCK < 2) begin : g_bad_block
         $error("BLOCK must be at least 2");
      end
      if (THR_LO == 0 || THR_LO > THR_HI) begin : g_bad_thr
         $error("THR_LO must lie in 1..THR_HI");
      end
   endgenerate

   logic    unit_any;
   logic    blk_wrap;
   irq_ev_e ev;

   assign unit_any = unit_ok_i || unit_err_i;

   su_block_ctr #(
      .BLOCK (BLOCK),
      .CW    (SU_W)
   ) i_blk (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr_i),
      .unit_i (unit_any),
      .cnt_o  (su_cnt_o),
      .wrap_o (blk_wrap)
   );

   su_err_bucket #(
      .THR_HI (THR_HI),
      .THR_LO (THR_LO),
      .EW     (ERR_W)
   ) i_bkt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (cnt_clr_i),
      .err_i     (unit_err_i),
      .inval_i   (unit_inval_i),
      .ok_i      (unit_ok_i),
      .leak_i    (blk_wrap),
      .thr_sel_i (thr_sel_i),
      .cnt_o     (err_cnt_o),
      .ev_o      (ev)
   );

   su_irq_ctrl i_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev),
      .stat_clr_i (stat_clr_i),
      .mask_i     (irq_mask_i),
      .stat_o     (irq_stat_o),
      .irq_o      (irq_o)
   );

endmodule

// File: rtl/su_err_monitor_chk.sv
module su_err_monitor_chk #(
   parameter int unsigned SU_W   = 8,
   parameter int unsigned ERR_W  = 7,
   parameter int unsigned THR_HI = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             unit_ok_i,
   input logic             unit_err_i,
   input logic             cnt_clr_i,
   input logic             irq_mask_i,
   input logic             stat_clr_i,
   input logic             irq_stat_o,
   input logic             irq_o,
   input logic [SU_W-1:0]  su_cnt_o,
   input logic [ERR_W-1:0] err_cnt_o
);

   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((unit_ok_i || unit_err_i) && !cnt_clr_i) |=> (su_cnt_o != $past(su_cnt_o)));

   p_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_err_i) |=> (err_cnt_o <= $past(err_cnt_o)));

   p_err_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_o <= ERR_W'(THR_HI));

   p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask_i |-> !irq_o);

   p_stat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stat_o && !stat_clr_i) |=> irq_stat_o);

   p_stat_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_stat_o && !unit_err_i) |=> !irq_stat_o);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr_i |=> (su_cnt_o == '0 && err_cnt_o == '0));

endmodule

bind su_err_monitor su_err_monitor_chk #(
   .SU_W   (SU_W),
   .ERR_W  (ERR_W),
   .THR_HI (THR_HI)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .unit_ok_i  (unit_ok_i),
   .unit_err_i (unit_err_i),
   .cnt_clr_i  (cnt_clr_i),
   .irq_mask_i (irq_mask_i),
   .stat_clr_i (stat_clr_i),
   .irq_stat_o (irq_stat_o),
   .irq_o      (irq_o),
   .su_cnt_o   (su_cnt_o),
   .err_cnt_o  (err_cnt_o)
);

// File: tb/test_su_err_monitor.sv
`timescale 1ns/1ps
module test_su_err_monitor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       unit_ok_i = 1'b0;
   logic       unit_err_i = 1'b0;
   logic       unit_inval_i = 1'b0;
   logic       thr_sel_i = 1'b0;
   logic       cnt_clr_i = 1'b0;
   logic       irq_mask_i = 1'b0;
   logic       stat_clr_i = 1'b0;
   logic       irq_stat_o;
   logic       irq_o;
   logic [7:0] su_cnt_o;
   logic [6:0] err_cnt_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   su_err_monitor i_su_err_monitor (
      .clk          (clk),
      .rst_n        (rst_n),
      .unit_ok_i    (unit_ok_i),
      .unit_err_i   (unit_err_i),
      .unit_inval_i (unit_inval_i),
      .thr_sel_i    (thr_sel_i),
      .cnt_clr_i    (cnt_clr_i),
      .irq_mask_i   (irq_mask_i),
      .stat_clr_i   (stat_clr_i),
      .irq_stat_o   (irq_stat_o),
      .irq_o        (irq_o),
      .su_cnt_o     (su_cnt_o),
      .err_cnt_o    (err_cnt_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one unit held across one rising edge, outputs sampled on the next falling edge
   task automatic unit(input bit ok, input bit err, input bit inv);
      @(negedge clk);
      unit_ok_i = ok; unit_err_i = err; unit_inval_i = inv;
      @(negedge clk);
      unit_ok_i = 1'b0; unit_err_i = 1'b0; unit_inval_i = 1'b0;
   endtask

   task automatic units(input int n, input bit ok, input bit err);
      for (int i = 0; i < n; i++) unit(ok, err, 1'b0);
   endtask

   task automatic clear_counters();
      @(negedge clk);
      cnt_clr_i = 1'b1;
      @(negedge clk);
      cnt_clr_i = 1'b0;
   endtask

   task automatic clear_stat();
      @(negedge clk);
      stat_clr_i = 1'b1;
      @(negedge clk);
      stat_clr_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 su_cnt", su_cnt_o, 0);
      chk("R1 err_cnt", err_cnt_o, 0);
      chk("R1 stat", irq_stat_o, 0);
      chk("R1 irq", irq_o, 0);
   endtask

   task automatic t_counting();
      units(3, 1'b1, 1'b0);
      units(2, 1'b0, 1'b1);
      chk("R2 su_cnt after 5 units", su_cnt_o, 5);
      chk("R3 err_cnt after 2 errored", err_cnt_o, 2);
      unit(1'b1, 1'b1, 1'b0);
      chk("R2 both pulses one unit", su_cnt_o, 6);
      chk("R3 both pulses errored", err_cnt_o, 3);
   endtask

   task automatic t_clear();
      @(negedge clk);
      cnt_clr_i = 1'b1; unit_err_i = 1'b1;
      @(negedge clk);
      cnt_clr_i = 1'b0; unit_err_i = 1'b0;
      chk("R8 su_cnt cleared", su_cnt_o, 0);
      chk("R8 err_cnt cleared", err_cnt_o, 0);
   endtask

   task automatic t_leak();
      clear_counters();
      units(3, 1'b0, 1'b1);
      units(252, 1'b1, 1'b0);
      chk("R4 before wrap su", su_cnt_o, 255);
      chk("R4 before wrap err", err_cnt_o, 3);
      unit(1'b1, 1'b0, 1'b0);
      chk("R4 wrap su", su_cnt_o, 0);
      chk("R4 leak err", err_cnt_o, 2);
      clear_counters();
      units(256, 1'b1, 1'b0);
      chk("R4 saturate at zero", err_cnt_o, 0);
      clear_counters();
      unit(1'b0, 1'b1, 1'b0);
      units(254, 1'b1, 1'b0);
      unit(1'b0, 1'b1, 1'b0);
      chk("R4 errored wrap su", su_cnt_o, 0);
      chk("R4 errored wrap net zero", err_cnt_o, 1);
   endtask

   task automatic t_thr64();
      thr_sel_i = 1'b0;
      clear_counters();
      units(64, 1'b0, 1'b1);
      chk("R5 64 at threshold", err_cnt_o, 64);
      chk("R5 no stat at threshold", irq_stat_o, 0);
      unit(1'b0, 1'b1, 1'b0);
      chk("R5 excess resets err", err_cnt_o, 0);
      chk("R5 excess sets stat", irq_stat_o, 1);
      chk("R6 irq unmasked", irq_o, 1);
   endtask

   task automatic t_mask_hold();
      @(negedge clk);
      irq_mask_i = 1'b1;
      #1;
      chk("R6 masked irq", irq_o, 0);
      chk("R6 mask keeps stat", irq_stat_o, 1);
      repeat (5) @(negedge clk);
      chk("R7 stat held", irq_stat_o, 1);
      irq_mask_i = 1'b0;
      #1;
      chk("R6 unmasked again", irq_o, 1);
      clear_stat();
      chk("R7 stat cleared", irq_stat_o, 0);
      chk("R7 irq after clear", irq_o, 0);
   endtask

   task automatic t_thr32();
      thr_sel_i = 1'b1;
      clear_counters();
      units(32, 1'b0, 1'b1);
      chk("R5 32 at threshold", err_cnt_o, 32);
      chk("R5 no stat at 32", irq_stat_o, 0);
      unit(1'b0, 1'b1, 1'b0);
      chk("R5 excess at 33", irq_stat_o, 1);
      chk("R5 err reset at 33", err_cnt_o, 0);
      clear_stat();
      unit(1'b0, 1'b1, 1'b0);
      chk("R9 no repeat after plain excess", irq_stat_o, 0);
   endtask

   task automatic t_repeat();
      thr_sel_i = 1'b1;
      clear_counters();
      units(32, 1'b0, 1'b1);
      unit(1'b0, 1'b1, 1'b1);
      chk("R5 invalid excess sets stat", irq_stat_o, 1);
      clear_stat();
      chk("R7 cleared before repeat", irq_stat_o, 0);
      unit(1'b0, 1'b1, 1'b0);
      chk("R9 repeat on errored unit", irq_stat_o, 1);
      @(negedge clk);
      stat_clr_i = 1'b1; unit_err_i = 1'b1;
      @(negedge clk);
      stat_clr_i = 1'b0; unit_err_i = 1'b0;
      chk("R7 set wins over clear", irq_stat_o, 1);
      clear_stat();
      unit(1'b1, 1'b0, 1'b0);
      unit(1'b0, 1'b1, 1'b0);
      chk("R9 no repeat after good unit", irq_stat_o, 0);
      chk("R3 err_cnt after repeats", err_cnt_o, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_counting();
      t_clear();
      t_leak();
      t_thr64();
      t_mask_hold();
      t_thr32();
      t_repeat();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule